// File: doc/BRIEF.md
# Timed Motor Speed Pattern Sequencer

This block commands a motor driver through a fixed, repeating program of seven moves. Each move pairs an 8-bit speed byte with a one-bit direction flag. The sequence covers stopping, running forward and running in reverse, at quarter, half and full speed. Each move is held for a fixed dwell time. The default dwell is 20,000,000 cycles, which is two seconds on a 10 MHz clock. The dwell length is a parameter, so a shorter value can be used in simulation.

The host supplies the clock, a synchronous active-high reset and an enable. While enable is high, an internal dwell counter advances once per cycle. When the counter completes a dwell, the move index steps forward, and after the last move it returns to the first. While enable is low, the block pauses: the counter, the move index and the outputs all hold. The current move index is brought out so that the sequence can be observed.

Top module: `motor_pattern_seq`

## Requirements
- R1: While reset is sampled high, the block returns to move 0 with speed 0, direction 1 and a cleared dwell counter. After reset is released with enable high, move 0 lasts a full DWELL_CYCLES cycles.
- R2: The move index runs through 0 to 6. The speed byte for each move, in index order, is 0, 128, 255, 128, 255, 0, 64.
- R3: Direction 1 means forward and 0 means reverse. Moves 1, 2 and 6 drive direction 1, and moves 3 and 4 drive direction 0.
- R4: During the stop moves (0 and 5), direction keeps the value left by the preceding move. It is 0 in move 5, and 1 in move 0 after a wrap.
- R5: Every move lasts exactly DWELL_CYCLES enabled cycles. The index advances on the clock edge at which the dwell counter holds DWELL_CYCLES-1.
- R6: After move 6 completes its dwell, the index returns to move 0 and the pattern repeats.
- R7: While enable is low, the dwell counter, the move index, the speed and the direction all hold. After enable returns, the interrupted move runs for only its remaining dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 MHz in the target system |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low pauses the sequencer |
| speed_o | output | 8 | Speed byte to the motor driver |
| dir_o | output | 1 | Direction to the driver, 1 forward, 0 reverse |
| step_o | output | 3 | Index of the current move, 0 to 6 |

## Verification
The bench measures the exact length of the first move after reset and of later moves. A design that is off by one on the dwell counter shows up as a move that is one cycle short or one cycle long. It checks the direction flag during both stop moves, where a design that cleared or forced the flag would send the wrong direction to the driver. It checks the wrap from the last move back to the first, which catches a sequencer that runs into an unused index. It pauses the block partway through a move and checks that the move then finishes only its remaining dwell; a design that reset or kept counting during the pause would finish the move at the wrong time. Random enable and reset patterns are compared against a cycle model.

// File: rtl/motor_pattern_seq.sv
module motor_pattern_seq #(
  parameter int unsigned DWELL_CYCLES = 20_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [7:0] speed_o,
  output logic       dir_o,
  output logic [2:0] step_o
);

  localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);
  localparam logic [2:0] FINAL_STEP = 3'd6;

  logic [CW-1:0] cnt_q;
  logic [2:0]    step_q;
  logic [2:0]    step_nx;
  logic          dir_q;
  logic          rst_q;

  function automatic logic [7:0] speed_of(input logic [2:0] s);
    case (s)
      3'd1, 3'd3: speed_of = 8'd128;
      3'd2, 3'd4: speed_of = 8'd255;
      3'd6:       speed_of = 8'd64;
      default:    speed_of = 8'd0;
    endcase
  endfunction

  function automatic logic dir_of(input logic [2:0] s);
    case (s)
      3'd1, 3'd2, 3'd6: dir_of = 1'b1;
      default:          dir_of = 1'b0;
    endcase
  endfunction

  wire dwell_done = (cnt_q == LAST);
  assign step_nx = (step_q == FINAL_STEP) ? 3'd0 : step_q + 3'd1;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      cnt_q  <= '0;
      step_q <= 3'd0;
      dir_q  <= 1'b1;
    end else if (en) begin
      if (dwell_done) begin
        cnt_q  <= '0;
        step_q <= step_nx;
        if (speed_of(step_nx) != 8'd0) dir_q <= dir_of(step_nx);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign speed_o = speed_of(step_q);
  assign dir_o   = dir_q;
  assign step_o  = step_q;

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst || rst_q)
    step_o <= FINAL_STEP); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst || rst_q)
    cnt_q <= LAST); // R5
  AST_HOLD_MID_DWELL: assert property (@(posedge clk) disable iff (rst || rst_q)
    (en && !dwell_done) |=> $stable(step_o)); // R5
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst || rst_q)
    (en && dwell_done && step_o == FINAL_STEP) |=> (step_o == 3'd0)); // R6
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst || rst_q)
    !en |=> ($stable(step_o) && $stable(cnt_q) && $stable(dir_o))); // R7
  AST_STOP_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst || rst_q)
    (speed_o == 8'd0) |-> $stable(dir_o)); // R4

endmodule

// File: tb/motor_pattern_seq_tb.sv
module motor_pattern_seq_tb;
  localparam int D = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] speed_o;
  logic       dir_o;
  logic [2:0] step_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit auto_chk = 1'b0;
  bit done = 1'b0;

  int m_step = 0;
  int m_cnt  = 0;
  bit m_dir  = 1'b1;

  always #10 clk = ~clk;

  motor_pattern_seq #(.DWELL_CYCLES(D)) u_dut (
    .clk(clk), .rst(rst), .en(en),
    .speed_o(speed_o), .dir_o(dir_o), .step_o(step_o)
  );

  function automatic int ref_speed(input int s);
    case (s)
      1, 3: return 128;
      2, 4: return 255;
      6:    return 64;
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_dir(input int s);
    return (s == 1 || s == 2 || s == 6);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_cnt = 0; m_dir = 1'b1;
    end else if (en) begin
      if (m_cnt == D - 1) begin
        m_cnt  = 0;
        m_step = (m_step == 6) ? 0 : m_step + 1;
        if (ref_speed(m_step) != 0) m_dir = ref_dir(m_step);
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (auto_chk) begin
      chk(int'(step_o) == m_step, "R2 step index", int'(step_o), m_step);
      chk(int'(speed_o) == ref_speed(m_step), "R2 speed code", int'(speed_o), ref_speed(m_step));
      if (ref_speed(m_step) == 0)
        chk(dir_o == m_dir, "R4 stop keeps dir", int'(dir_o), int'(m_dir));
      else
        chk(dir_o == m_dir, "R3 moving dir", int'(dir_o), int'(m_dir));
    end
  end

  task automatic wait_change(output int n);
    logic [2:0] s0;
    s0 = step_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (step_o == s0 && n < 10 * D);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(step_o == 3'd0, "R1 reset step", int'(step_o), 0);
    chk(speed_o == 8'd0, "R1 reset speed", int'(speed_o), 0);
    chk(dir_o == 1'b1, "R1 reset dir", int'(dir_o), 1);

    rst = 1'b0; en = 1'b1; auto_chk = 1'b1;
    wait_change(n);
    chk(n == D, "R1 first move full dwell", n, D);
    chk(step_o == 3'd1 && speed_o == 8'd128, "R2 half forward", int'(speed_o), 128);
    chk(dir_o == 1'b1, "R3 forward", int'(dir_o), 1);
    wait_change(n);
    chk(n == D, "R5 dwell length", n, D);
    chk(speed_o == 8'd255 && dir_o, "R2 full forward", int'(speed_o), 255);
    wait_change(n);
    chk(speed_o == 8'd128 && !dir_o, "R3 half reverse", int'(dir_o), 0);
    wait_change(n);
    chk(speed_o == 8'd255 && !dir_o, "R3 full reverse", int'(dir_o), 0);
    wait_change(n);
    chk(step_o == 3'd5 && speed_o == 8'd0, "R2 second stop", int'(speed_o), 0);
    chk(dir_o == 1'b0, "R4 dir kept in move 5", int'(dir_o), 0);
    wait_change(n);
    chk(speed_o == 8'd64 && dir_o, "R2 quarter forward", int'(speed_o), 64);
    wait_change(n);
    chk(n == D, "R6 last move dwell", n, D);
    chk(step_o == 3'd0, "R6 wrap to move 0", int'(step_o), 0);
    chk(dir_o == 1'b1, "R4 dir kept after wrap", int'(dir_o), 1);

    wait_change(n);
    repeat (5) @(negedge clk);
    en = 1'b0;
    begin
      logic [2:0] s; logic [7:0] v; logic d;
      s = step_o; v = speed_o; d = dir_o;
      repeat (30) @(negedge clk);
      chk(step_o == s, "R7 pause holds step", int'(step_o), int'(s));
      chk(speed_o == v, "R7 pause holds speed", int'(speed_o), int'(v));
      chk(dir_o == d, "R7 pause holds dir", int'(dir_o), int'(d));
    end
    en = 1'b1;
    wait_change(n);
    chk(n == D - 5, "R7 remaining dwell after pause", n, D - 5);

    for (int i = 0; i < 4000; i++) begin
      en  = ($urandom % 4) != 0;
      rst = ($urandom % 700) == 0;
      @(negedge clk);
    end
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule